// File: doc/BRIEF.md
# I2C Master with Selectable Wait Point

This block is a single-master I2C controller that a processor drives through a small write-only register port. It produces start, repeated start and stop conditions, sends a 7-bit address with the read/write bit, and then transmits or receives data bytes on open-drain SCL and SDA lines. At each point where software must act, the block holds SCL low and raises a one-clock interrupt pulse. An 8-bit status word describes the situation at that point.

A timing bit selects where a data byte stops for software. With the bit clear, the wait comes after the 8th clock, before the acknowledge slot. With it set, the wait comes after the 9th clock, after the acknowledge slot. The address byte always waits after its 9th clock. A repeated start or a stop may only be requested from a 9th-clock wait, so software sets the timing bit before it asks for either one. A separate enable decides whether the stop condition raises an interrupt.

Registers are selected by `wr_addr`. Address 0 is the data byte. Address 1 is control: bit 0 start trigger, bit 1 stop trigger, bit 2 wait release, bit 3 wait timing (1 = after 9th clock), bit 4 stop-interrupt enable, bit 5 acknowledge enable for received bytes. Address 2 is the half-period divider. The triggers and the release act only for the write that carries them. The other control bits are kept.

Top module: `i2c_wait_master`

## Requirements
- R1: After reset, `status` is 0, `irq` is 0, and neither `scl_oe` nor `sda_oe` pulls its line low.
- R2: When an address byte completes, `irq` pulses after its 9th clock whatever the timing bit is. `status` then reads 1000_t110, where t (bit 3) is 1 if the R/W bit sent was 0 (transmit) and 0 if it was 1 (receive).
- R3: With the timing bit at 0, a data byte raises `irq` after its 8th clock. `status` reads 1000_t000, so start-detected (bit 1) and ACK (bit 2) are both 0.
- R4: With the timing bit at 1, a data byte raises `irq` after its 9th clock. `status` reads 1000_ta00, where a (bit 2) is 1 when SDA was low during the 9th clock.
- R5: At every wait point, SCL stays pulled low until software releases the wait, and `irq` is never high for two clocks in a row.
- R6: A start trigger at a 9th-clock wait produces a repeated start. The following address byte again gives the R2 status.
- R7: A stop trigger at a 9th-clock wait drives a stop condition and releases both lines. `status` then reads 0000_0001.
- R8: The stop condition raises `irq` only when the stop-interrupt enable (control bit 4) is 1.
- R9: Start and stop triggers written during an 8th-clock wait are ignored. SCL stays low, `status` is unchanged and no interrupt follows.
- R10: Transmitted bytes go out MSB first. A received byte appears on `rx_data` after its 8th clock. In receive mode the block drives the acknowledge slot low exactly when control bit 5 is 1.
- R11: A start, address, data, restart, address, data, stop sequence with the stop interrupt enabled gives 7 interrupts with the timing bit at 0 and 5 with it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 control, 2 divider |
| wr_data | input | 8 | Write data |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | One-clock interrupt pulse |
| status | output | 8 | {master, 000, transmit, ack, start-seen, stop-seen} |
| rx_data | output | 8 | Last received byte |

## Verification
A wrong sequencer state shows up at the ports within one byte time. The interrupt comes one SCL clock early or late, or the status word at that interrupt carries the wrong ack, start or direction bit. A missed or extra wait changes the number of interrupts over a full restart sequence, and a stray release lets SCL rise while software still owes an action. Errors in the shift path appear as a byte that the bus partner sees, or that `rx_data` returns, differing from the byte that was sent.

// File: rtl/i2c_wait_master.sv
module i2c_wait_master #(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq,
  output logic [7:0] status,
  output logic [7:0] rx_data
);
  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_DIV = 2'd2;
  localparam logic [1:0] W_ADR = 2'd0, W_8 = 2'd1, W_9 = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_STA1, S_STA2, S_LO, S_HI, S_WT, S_RS1, S_RS2, S_SP1, S_SP2, S_SP3
  } st_t;

  st_t              st;
  logic [1:0]       wkind;
  logic [DIV_W-1:0] div, cnt;
  logic [7:0]       shreg;
  logic [3:0]       bitcnt;
  logic             is_addr, wtim, spie, acke;
  logic             msts, trc, ackd, std, spd;

  wire wr_dat = wr_en && wr_addr == A_DATA;
  wire wr_ctl = wr_en && wr_addr == A_CTRL;
  wire stt    = wr_ctl && wr_data[0];
  wire spt    = wr_ctl && wr_data[1];
  wire wrel   = wr_ctl && wr_data[2];
  wire hi_ph  = st inside {S_STA1, S_HI, S_RS2, S_SP2, S_SP3};
  wire run    = st != S_IDLE && st != S_WT && (!hi_ph || scl_in);
  wire tick   = run && cnt == div;

  assign status = {msts, 3'b000, trc, ackd, std, spd};
  assign scl_oe = st inside {S_STA2, S_LO, S_WT, S_RS1, S_SP1};

  always_comb begin
    case (st)
      S_STA1, S_STA2, S_SP1, S_SP2: sda_oe = 1'b1;
      S_LO, S_HI: sda_oe = bitcnt[3] ? (!is_addr && !trc && acke)
                                     : ((is_addr || trc) && !shreg[7]);
      default: sda_oe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wkind <= W_ADR; div <= DIV_W'(DIV_INIT); cnt <= '0;
      shreg <= '0; bitcnt <= '0; is_addr <= 1'b0; rx_data <= '0; irq <= 1'b0;
      wtim <= 1'b0; spie <= 1'b0; acke <= 1'b0;
      msts <= 1'b0; trc <= 1'b0; ackd <= 1'b0; std <= 1'b0; spd <= 1'b0;
    end else begin
      irq <= 1'b0;
      cnt <= tick ? '0 : (run ? cnt + 1'b1 : cnt);
      if (wr_ctl) begin
        wtim <= wr_data[3]; spie <= wr_data[4]; acke <= wr_data[5];
      end
      if (wr_en && wr_addr == A_DIV) div <= wr_data[DIV_W-1:0];
      case (st)
        S_IDLE: if (stt) begin
          st <= S_STA1; msts <= 1'b1; std <= 1'b1; spd <= 1'b0; ackd <= 1'b0;
        end
        S_STA1: if (tick) st <= S_STA2;
        S_STA2: if (tick) begin st <= S_WT; wkind <= W_ADR; end
        S_LO:   if (tick) st <= S_HI;
        S_HI: if (tick) begin
          if (!bitcnt[3]) begin
            shreg <= {shreg[6:0], sda_in};
            if (bitcnt == 4'd7 && !is_addr && !trc) rx_data <= {shreg[6:0], sda_in};
            if (bitcnt == 4'd7 && !is_addr && !wtim) begin
              st <= S_WT; wkind <= W_8; irq <= 1'b1;
            end else begin
              bitcnt <= bitcnt + 4'd1; st <= S_LO;
            end
          end else if (is_addr || wtim) begin
            ackd <= !sda_in; st <= S_WT; wkind <= W_9; irq <= 1'b1;
          end else begin
            ackd <= 1'b0; bitcnt <= '0; st <= S_LO;
          end
        end
        S_WT: begin
          case (wkind)
            W_ADR: if (wr_dat) begin
              shreg <= wr_data; trc <= !wr_data[0]; is_addr <= 1'b1;
              bitcnt <= '0; st <= S_LO;
            end
            W_8: if (wr_dat || wrel) begin
              if (wr_dat) shreg <= wr_data;
              bitcnt <= 4'd8; st <= S_LO;
            end
            default: if (stt) st <= S_RS1;
              else if (spt) st <= S_SP1;
              else if (wr_dat || wrel) begin
                if (wr_dat) shreg <= wr_data;
                bitcnt <= '0; is_addr <= 1'b0; std <= 1'b0; ackd <= 1'b0; st <= S_LO;
              end
          endcase
        end
        S_RS1: if (tick) st <= S_RS2;
        S_RS2: if (tick) begin st <= S_STA1; std <= 1'b1; ackd <= 1'b0; end
        S_SP1: if (tick) st <= S_SP2;
        S_SP2: if (tick) st <= S_SP3;
        S_SP3: if (tick) begin
          st <= S_IDLE; irq <= spie;
          msts <= 1'b0; trc <= 1'b0; ackd <= 1'b0; std <= 1'b0; spd <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_scl_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WT && !wr_en) |=> scl_oe);
  assert_addr_master_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msts |-> !spd);
  assert_stop_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && spd) |-> status == 8'h01);
  assert_stop_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && spd) |-> spie);
  assert_w8_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WT && wkind == W_8 && !wr_dat && !wrel) |=> st == S_WT);
  assert_sda_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI && $past(st == S_HI)) |-> $stable(sda_oe));
endmodule

// File: tb/i2c_wait_master_tb.sv
module i2c_wait_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic scl_oe, sda_oe, irq;
  logic [7:0] status, rx_data;
  logic slv_pull = 1'b0;
  wire scl_bus = !scl_oe;
  wire sda_bus = !(sda_oe || slv_pull);

  int vectors = 0, miscompares = 0, nirq = 0;
  int sbit = -1;
  logic s_addr = 1'b0, s_read = 1'b0;
  logic [7:0] s_sh = '0, s_got = '0, s_tx = '0;

  always #5 clk = !clk;

  i2c_wait_master u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .irq(irq), .status(status), .rx_data(rx_data));

  always @(negedge clk) if (irq === 1'b1) nirq++;

  always @(negedge sda_bus) if (scl_bus === 1'b1) begin sbit = -1; s_addr = 1'b1; end
  always @(posedge scl_bus) if (sbit >= 0 && sbit < 8) s_sh = {s_sh[6:0], sda_bus};
  always @(negedge scl_bus) begin
    sbit = sbit + 1;
    if (sbit == 8) begin
      if (s_addr) begin s_read = s_sh[0]; slv_pull = 1'b1; end
      else if (!s_read) begin s_got = s_sh; slv_pull = 1'b1; end
      else slv_pull = 1'b0;
    end else if (sbit == 9) begin
      sbit = 0;
      slv_pull = (s_addr && s_read) ? !s_tx[7] : 1'b0;
      s_addr = 1'b0;
    end else if (!s_addr && s_read && sbit >= 1 && sbit < 8) slv_pull = !s_tx[7-sbit];
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ctl(input logic wt, sp, ak, stt, spt, rel);
    wr(2'd1, {2'b00, ak, sp, wt, rel, spt, stt});
  endtask

  task automatic wait_irq(input string req);
    logic seen = 1'b0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    check(req, {7'd0, seen}, 8'd1);
  endtask

  task automatic run_seq(input logic wt, rw, sp, ak, input logic [7:0] d);
    int n0 = nirq;
    logic [7:0] tb = rw ? 8'h00 : 8'h08;
    logic ackx = rw ? ak : 1'b1;
    s_tx = d;
    for (int pass = 0; pass < 2; pass++) begin
      ctl(wt, sp, ak, 1'b1, 1'b0, 1'b0);
      repeat (20) @(negedge clk);
      wr(2'd0, {7'h2A, rw});
      wait_irq(pass == 0 ? "R2" : "R6");
      check(pass == 0 ? "R2 addr status" : "R6 restart addr status", status, 8'h86 | tb);
      if (!wt) begin
        if (rw) ctl(1'b0, sp, ak, 1'b0, 1'b0, 1'b1); else wr(2'd0, d);
        wait_irq("R3");
        check("R3 8th-clock status", status, 8'h80 | tb);
        repeat (10) @(negedge clk);
        check("R5 scl held", {7'd0, scl_oe}, 8'd1);
        if (pass == 0) begin
          int nb = nirq;
          ctl(1'b0, sp, ak, 1'b1, 1'b1, 1'b0);
          repeat (30) @(negedge clk);
          check("R9 status kept", status, 8'h80 | tb);
          check("R9 scl held", {7'd0, scl_oe}, 8'd1);
          check("R9 no irq", 8'(nirq - nb), 8'd0);
        end
        ctl(1'b1, sp, ak, 1'b0, 1'b0, 1'b1);
      end else begin
        if (rw) ctl(1'b1, sp, ak, 1'b0, 1'b0, 1'b1); else wr(2'd0, d);
      end
      wait_irq("R4");
      check("R4 9th-clock status", status, 8'h80 | tb | {5'd0, ackx, 2'd0});
      if (rw) check("R10 rx byte", rx_data, d); else check("R10 tx byte", s_got, d);
      repeat (10) @(negedge clk);
      check("R5 scl held 9th", {7'd0, scl_oe}, 8'd1);
    end
    ctl(1'b1, sp, ak, 1'b0, 1'b1, 1'b0);
    if (sp) begin
      wait_irq("R8");
      check("R7 stop status", status, 8'h01);
    end else begin
      repeat (60) @(negedge clk);
      check("R7 stop status", status, 8'h01);
    end
    repeat (5) @(negedge clk);
    check("R7 lines released", {6'd0, scl_oe, sda_oe}, 8'd0);
    check("R8 R11 irq count", 8'(nirq - n0), 8'((wt ? 5 : 7) - (sp ? 0 : 1)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status", status, 8'h00);
    check("R1 lines", {5'd0, irq, scl_oe, sda_oe}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {status[7:1], irq | scl_oe | sda_oe}, 8'd0);
    wr(2'd2, 8'd1);
    for (int i = 0; i < 16; i++)
      run_seq(i[3], i[2], i[1], i[0], 8'hA5 ^ 8'(i * 37));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule